// File: doc/BRIEF.md
# Memory Controller Interrupt Unit

This block collects the interrupt events of an asynchronous external-memory controller and turns them into one level interrupt line. There are two sources. One is a one-cycle timeout pulse from the access sequencer. The other is a rising edge on the external wait/ready pin, which counts only while the controller runs in NAND flash mode. The wait pin is first passed through a two-flop synchronizer.

Each source has a sticky raw status bit and an enable bit. Raw status sets on every event, whether or not the source is enabled, and software clears it by writing 1. The enable bits change only through two addresses: one address sets bits where a 1 is written, and the other clears them. Reading either of those addresses returns the current enables. A masked view returns raw AND enable, and the interrupt output is the OR of that view.

A build parameter removes the wait source for parts that have no wait pin. In such a build the wait bits read as 0 and ignore writes.

Top module: `mem_irq_ctrl`

## Requirements
- R1: After reset, every raw status bit and every enable bit is 0, every address reads 0, and irq_o is low.
- R2: A write to address 2 sets each enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged. Bit 0 is the timeout enable and bit 1 is the wait-edge enable.
- R3: A write to address 3 clears each enable bit whose write-data bit is 1. The raw status is not affected.
- R4: A read of address 2 or address 3 returns the current enable bits in bits [1:0], with 0 in the upper bits.
- R5: A timeout_i pulse sampled high at a clock edge sets raw status bit 0 on that edge, even if its enable is 0.
- R6: A rising edge on wait_i sets raw status bit 1 on the third clock edge after the change, but only if nand_mode_i is high. With nand_mode_i low, a wait edge has no effect.
- R7: A read of address 0 returns the raw status. A write of 1 to a bit at address 0 clears that bit, and a write of 0 leaves it set. If an event arrives in the same cycle as a clear, the event wins.
- R8: A read of address 1 returns raw AND enable. irq_o is high while any masked bit is 1, and it stays high until that bit is cleared or disabled.
- R9: With HAS_WAIT = 0, raw status bit 1 and enable bit 1 always read 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nand_mode_i | input | 1 | Controller is in NAND flash mode |
| wait_i | input | 1 | Asynchronous external wait/ready pin |
| timeout_i | input | 1 | One-cycle access timeout pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 raw, 1 masked, 2 enable set, 3 enable clear |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds two copies of the block that share the same stimulus. The first copy uses HAS_WAIT = 1. It covers the full enable, status and masking paths, the synchronizer latency of the wait edge, and the gating by NAND mode. The second copy uses HAS_WAIT = 0. It shows that the wait bits stay at zero through the same writes and the same pin edges that set them in the first copy.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned SRC_TMO  = 0;
  localparam int unsigned SRC_WAIT = 1;
  localparam logic [1:0]  ADDR_STS = 2'd0;
  localparam logic [1:0]  ADDR_MSK = 2'd1;
  localparam logic [1:0]  ADDR_SET = 2'd2;
  localparam logic [1:0]  ADDR_CLR = 2'd3;
endpackage

// File: rtl/mirq_wait_edge.sv
module mirq_wait_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic nand_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= wait_i;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = nand_i & sync_q[SYNC_STAGES-1] & ~prev_q;

  // R6: an edge yields exactly one pulse
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mirq_src_bit.sv
module mirq_src_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic sts_clr_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic sts_o,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= 1'b0;
    else if (ev_i) sts_o <= 1'b1;       // event beats clear
    else if (sts_clr_i) sts_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else if (en_clr_i) en_o <= 1'b0;    // clear beats set
    else if (en_set_i) en_o <= 1'b1;
  end

  a_r5_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> sts_o);
  a_r7_status_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o && !sts_clr_i |=> sts_o);
  a_r3_clear_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> !en_o);
  a_r2_set_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i && !en_clr_i |=> en_o);
endmodule

// File: rtl/mem_irq_ctrl.sv
module mem_irq_ctrl
  import mirq_pkg::*;
#(
  parameter bit          HAS_WAIT    = 1'b1,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nand_mode_i,
  input  logic              wait_i,
  input  logic              timeout_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] ev, sts, en, sts_clr, en_set, en_clr, msk;
  logic               wait_rise;

  assign sts_clr = (wr_en_i && addr_i == ADDR_STS) ? wdata_i[NUM_SRC-1:0] : '0;
  assign en_set  = (wr_en_i && addr_i == ADDR_SET) ? wdata_i[NUM_SRC-1:0] : '0;
  assign en_clr  = (wr_en_i && addr_i == ADDR_CLR) ? wdata_i[NUM_SRC-1:0] : '0;

  generate
    if (HAS_WAIT) begin : g_wait
      mirq_wait_edge #(.SYNC_STAGES(SYNC_STAGES)) u_wait_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wait_i (wait_i),
        .nand_i (nand_mode_i),
        .rise_o (wait_rise)
      );
      // R6: no wait event outside NAND mode
      a_r6_nand_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nand_mode_i |=> !sts[SRC_WAIT] || $past(sts[SRC_WAIT]));
    end else begin : g_no_wait
      logic unused_wait;
      assign unused_wait = wait_i ^ nand_mode_i;
      assign wait_rise   = 1'b0;
      a_r9_absent_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sts[SRC_WAIT] && !en[SRC_WAIT]);
    end
  endgenerate

  always_comb begin
    ev           = '0;
    ev[SRC_TMO]  = timeout_i;
    ev[SRC_WAIT] = wait_rise;
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == SRC_WAIT && !HAS_WAIT) begin : g_tie
        logic unused_src;
        assign unused_src = ev[i] ^ sts_clr[i] ^ en_set[i] ^ en_clr[i];
        assign sts[i] = 1'b0;
        assign en[i]  = 1'b0;
      end else begin : g_bit
        mirq_src_bit u_bit (
          .clk_i     (clk_i),
          .rst_ni    (rst_ni),
          .ev_i      (ev[i]),
          .sts_clr_i (sts_clr[i]),
          .en_set_i  (en_set[i]),
          .en_clr_i  (en_clr[i]),
          .sts_o     (sts[i]),
          .en_o      (en[i])
        );
      end
    end
  endgenerate

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

  assign msk   = sts & en;
  assign irq_o = |msk;

  always_comb begin
    unique case (addr_i)
      ADDR_STS: rdata_o = {{PAD_W{1'b0}}, sts};
      ADDR_MSK: rdata_o = {{PAD_W{1'b0}}, msk};
      default:  rdata_o = {{PAD_W{1'b0}}, en};
    endcase
  end

  // R8: the interrupt stays up while the masked source is neither cleared nor disabled
  a_r8_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !wr_en_i |=> irq_o);
endmodule

// File: tb/mem_irq_ctrl_bench.sv
module mem_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nand_mode = 1'b0, wait_pin = 1'b0, tmo = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata, rdata_b;
  logic       irq, irq_b;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  mem_irq_ctrl #(.HAS_WAIT(1'b1)) u_mem_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nand_mode_i(nand_mode), .wait_i(wait_pin),
    .timeout_i(tmo), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq));

  mem_irq_ctrl #(.HAS_WAIT(1'b0)) u_mem_irq_ctrl_nw (
    .clk_i(clk), .rst_ni(rst_n), .nand_mode_i(nand_mode), .wait_i(wait_pin),
    .timeout_i(tmo), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_b), .irq_o(irq_b));

  typedef struct packed {
    logic       w;
    logic [1:0] wa;
    logic [7:0] wd;
    logic       t;
    logic [1:0] ra;
    logic [7:0] er;
    logic       ei;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 8'h01, 1'b0, 2'd2, 8'h01, 1'b0},  // R2 set
    '{1'b0, 2'd0, 8'h00, 1'b1, 2'd0, 8'h01, 1'b1},  // R5 timeout
    '{1'b0, 2'd0, 8'h00, 1'b0, 2'd1, 8'h01, 1'b1},  // R8 masked
    '{1'b1, 2'd3, 8'h01, 1'b0, 2'd3, 8'h00, 1'b0},  // R3 disable
    '{1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h01, 1'b0},  // R3 raw kept
    '{1'b1, 2'd0, 8'h01, 1'b0, 2'd0, 8'h00, 1'b0},  // R7 w1c
    '{1'b1, 2'd2, 8'h03, 1'b0, 2'd2, 8'h03, 1'b0},  // R2 both
    '{1'b1, 2'd2, 8'h00, 1'b0, 2'd3, 8'h03, 1'b0},  // R2/R4 zero write
    '{1'b1, 2'd0, 8'h01, 1'b1, 2'd0, 8'h01, 1'b1},  // R7 event wins
    '{1'b1, 2'd0, 8'h00, 1'b0, 2'd0, 8'h01, 1'b1},  // R7 zero write
    '{1'b1, 2'd0, 8'h01, 1'b0, 2'd1, 8'h00, 1'b0}   // R8 irq drops
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1", rdata, 8'h00);
    end
    chk("R1 irq", {7'd0, irq}, 8'h00);

    foreach (VEC[i]) begin
      @(negedge clk);
      wr = VEC[i].w; addr = VEC[i].wa; wdata = VEC[i].wd; tmo = VEC[i].t;
      @(posedge clk); #1;
      wr = 1'b0; tmo = 1'b0; addr = VEC[i].ra; #1;
      chk($sformatf("R2-8 vec%0d rdata", i), rdata, VEC[i].er);
      chk($sformatf("R8 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i].ei});
    end

    // R6: wait edge outside NAND mode is ignored
    @(negedge clk); nand_mode = 1'b0; wait_pin = 1'b1; addr = 2'd0;
    cyc(5);
    chk("R6 no nand", rdata, 8'h00);
    wait_pin = 1'b0;
    cyc(4);
    nand_mode = 1'b1; wait_pin = 1'b1;
    cyc(2);
    chk("R6 latency 2 edges", rdata, 8'h00);
    cyc(1);
    chk("R6 latency 3 edges", rdata, 8'h02);
    chk("R8 wait irq", {7'd0, irq}, 8'h01);
    cyc(3);
    chk("R6 level no retrigger", rdata, 8'h02);

    // R9: build without wait source
    chk("R9 raw", rdata_b, 8'h00);
    addr = 2'd2; #1;
    chk("R9 enable", rdata_b, 8'h01);
    chk("R4 set addr", rdata, 8'h03);
    addr = 2'd1; #1;
    chk("R9 irq", {7'd0, irq_b}, 8'h00);

    // R7 clear wait status, R3 clear leaves other enable
    @(negedge clk); wr = 1'b1; addr = 2'd0; wdata = 8'h02;
    @(negedge clk); wr = 1'b1; addr = 2'd3; wdata = 8'h02;
    @(negedge clk); wr = 1'b0; addr = 2'd3; #1;
    chk("R3 partial clear", rdata, 8'h01);
    addr = 2'd0; #1;
    chk("R7 wait cleared", rdata, 8'h00);
    chk("R8 irq low", {7'd0, irq}, 8'h00);

    // R1 async reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    addr = 2'd2; #1;
    chk("R1 reset enables", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule